// File: doc/BRIEF.md
# SDRAM Command Issue Controller

This block turns a single software request into SDRAM command pin activity for one or two attached memory devices. A request carries a 3-bit command code, a select bit for each device, a 4-bit refresh repeat count and a 14-bit mode-register value. Once accepted, the request drives precharge-all, auto-refresh, load-mode-register, self-refresh, power-down or clock-enable restore on the chip-select, RAS, CAS, WE, address and CKE outputs.

Requests that break the device-select rules are dropped before they reach the pins. A request that selects no device, a reserved command code, or a request that arrives while an earlier one is still in progress is also dropped. Every dropped request raises a sticky error flag, which software clears. An auto-refresh request issues a burst of back-to-back refreshes. Each refresh is followed by a fixed number of NOP cycles so that the refresh-cycle time is met. A busy output covers the whole operation.

Top module: `sdram_cmd_issue`

## Requirements
- R1: Code 2 (precharge all) drives one cycle with CS low on the selected devices, RAS=0, CAS=1, WE=0 and address bit 10 high.
- R2: Code 3 (auto-refresh) with count field N drives N+1 commands with RAS=0, CAS=0, WE=1 and CKE high. Each command is followed by TRFC cycles of NOP (RAS=CAS=WE=1, CS low on the selected devices).
- R3: Code 4 (load mode) drives one cycle with RAS=CAS=WE=0 and the 14-bit mode value on the address lines.
- R4: A request with both select bits at 0 drives no command (both CS high), does not raise busy, and sets the error flag.
- R5: With two devices fitted (DUAL=1), a precharge-all or auto-refresh request with only one select bit set is ignored and sets the error flag.
- R6: With one device fitted (DUAL=0), a request with the second device's select bit (bank_b) set is ignored and sets the error flag. The same command with only bank_a set is carried out.
- R7: Code 5 (self-refresh) drives the auto-refresh encoding with CKE low in the same cycle. CKE stays low until a code 0 (normal) or code 1 (clock enable) request restores it high.
- R8: Code 6 (power-down) drives CKE low together with a NOP on the selected devices.
- R9: Busy rises in the first command cycle and stays high through the last NOP gap. A request made while busy is high is ignored and sets the error flag.
- R10: The error flag stays set until err_clr is asserted. When err_clr and an ignored request fall in the same cycle, the flag stays set.
- R11: Code 7 is reserved. It is ignored and sets the error flag.
- R12: Out of reset, and whenever busy is low, both chip selects are high. After reset, busy and error are low and CKE is high.
- R13: cs_n[0] follows bank_a and cs_n[1] follows bank_b. An unselected device's chip select stays high during the command and during its NOP gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Software request strobe, one cycle |
| req_mode | input | 3 | Command code |
| req_bank_a | input | 1 | Select device 0 |
| req_bank_b | input | 1 | Select device 1 |
| req_nrf | input | 4 | Refresh repeat count minus one |
| req_mrv | input | 14 | Mode-register value |
| err_clr | input | 1 | Clears the error flag |
| sd_cs_n | output | 2 | Per-device chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 14 | Address lines |
| sd_cke | output | 1 | Clock enable |
| busy | output | 1 | Request in progress |
| err | output | 1 | Sticky flag for an ignored request |

## Verification
Two things can fall in the same cycle: a software clear of the error flag and a new request that has to be dropped. The first case is provoked by setting the flag with an empty-select request, then driving err_clr together with a second illegal request in a single cycle. The flag must still read high afterwards, and a later clear on its own must bring it low. The second case is a request that arrives during the NOP gap of a refresh burst. It must set the flag and must never show up on the pins.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  typedef enum logic [2:0] {
    MD_NORMAL = 3'd0,
    MD_CLKEN  = 3'd1,
    MD_PALL   = 3'd2,
    MD_AREF   = 3'd3,
    MD_LMR    = 3'd4,
    MD_SELF   = 3'd5,
    MD_PDOWN  = 3'd6,
    MD_RSVD   = 3'd7
  } sd_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_CMD  = 2'd1,
    SQ_GAP  = 2'd2
  } sq_state_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_ctl_t;

  localparam sd_ctl_t CTL_NOP  = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sd_ctl_t CTL_PALL = '{ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam sd_ctl_t CTL_AREF = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
  localparam sd_ctl_t CTL_LMR  = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

  // Legality of a request given the number of fitted devices.
  function automatic logic req_ok(input logic dual, input sd_mode_e m,
                                  input logic a, input logic b);
    logic ok;
    ok = (a | b) && (m != MD_RSVD);
    if (dual) begin
      if ((m == MD_PALL) || (m == MD_AREF)) ok = ok && a && b;
    end else begin
      ok = ok && !b;
    end
    return ok;
  endfunction

  // Control-pin encoding of the command cycle.
  function automatic sd_ctl_t ctl_for(input sd_mode_e m);
    case (m)
      MD_PALL:         return CTL_PALL;
      MD_AREF, MD_SELF: return CTL_AREF;
      MD_LMR:          return CTL_LMR;
      default:         return CTL_NOP;
    endcase
  endfunction

  // Cycles busy stays high for a refresh burst of nrf+1 commands.
  function automatic int unsigned burst_cycles(input int unsigned nrf,
                                               input int unsigned trfc);
    return (nrf + 1) * (trfc + 1);
  endfunction

endpackage

// File: rtl/sdram_req_check.sv
module sdram_req_check
  import sdram_cmd_pkg::*;
#(
  parameter bit DUAL = 1'b1
) (
  input  logic     req_valid,
  input  logic     busy,
  input  sd_mode_e mode,
  input  logic     bank_a,
  input  logic     bank_b,
  output logic     accept,
  output logic     reject
);
  logic legal;

  always_comb begin
    legal  = req_ok(DUAL, mode, bank_a, bank_b);
    accept = req_valid && !busy && legal;
    reject = req_valid && (busy || !legal);
  end
endmodule

// File: rtl/sdram_seq.sv
module sdram_seq
  import sdram_cmd_pkg::*;
#(
  parameter int TRFC   = 3,
  parameter int NRF_W  = 4,
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  sd_mode_e          mode,
  input  logic              bank_a,
  input  logic              bank_b,
  input  logic [NRF_W-1:0]  nrf,
  input  logic [ADDR_W-1:0] mrv,
  output sq_state_e         state,
  output sd_mode_e          cur_mode,
  output logic [1:0]        cur_banks,
  output logic [ADDR_W-1:0] cur_mrv,
  output logic              cmd_fire,
  output logic              last_done
);
  localparam int GAP_W = (TRFC < 2) ? 1 : $clog2(TRFC);
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(TRFC - 1);

  logic [GAP_W-1:0] gap_cnt;
  logic [NRF_W-1:0] rep_left;
  logic             is_aref;
  logic             gap_end;

  assign is_aref   = (cur_mode == MD_AREF);
  assign gap_end   = (state == SQ_GAP) && (gap_cnt == '0);
  assign cmd_fire  = (state == SQ_CMD);
  assign last_done = (gap_end && (rep_left == '0)) ||
                     (cmd_fire && !is_aref);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      cur_mode  <= MD_NORMAL;
      cur_banks <= 2'b00;
      cur_mrv   <= '0;
      gap_cnt   <= '0;
      rep_left  <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (accept) begin
            state     <= SQ_CMD;
            cur_mode  <= mode;
            cur_banks <= {bank_b, bank_a};
            cur_mrv   <= mrv;
            rep_left  <= (mode == MD_AREF) ? nrf : '0;
          end
        end
        SQ_CMD: begin
          if (is_aref) begin
            state   <= SQ_GAP;
            gap_cnt <= GAP_LOAD;
          end else begin
            state <= SQ_IDLE;
          end
        end
        SQ_GAP: begin
          if (gap_cnt == '0) begin
            if (rep_left == '0) begin
              state <= SQ_IDLE;
            end else begin
              rep_left <= rep_left - 1'b1;
              state    <= SQ_CMD;
            end
          end else begin
            gap_cnt <= gap_cnt - 1'b1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdram_cke_reg.sv
module sdram_cke_reg
  import sdram_cmd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     accept,
  input  sd_mode_e mode,
  output logic     cke
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cke <= 1'b1;
    end else if (accept) begin
      case (mode)
        MD_SELF, MD_PDOWN:   cke <= 1'b0;
        MD_NORMAL, MD_CLKEN: cke <= 1'b1;
        default:             cke <= cke;
      endcase
    end
  end
endmodule

// File: rtl/sdram_pin_drv.sv
module sdram_pin_drv
  import sdram_cmd_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  sq_state_e         state,
  input  sd_mode_e          cur_mode,
  input  logic [1:0]        cur_banks,
  input  logic [ADDR_W-1:0] cur_mrv,
  output logic [1:0]        cs_n,
  output sd_ctl_t           ctl,
  output logic [ADDR_W-1:0] addr
);
  localparam int A10 = 10;

  always_comb begin
    cs_n = 2'b11;
    ctl  = CTL_NOP;
    addr = '0;
    case (state)
      SQ_CMD: begin
        cs_n = ~cur_banks;
        ctl  = ctl_for(cur_mode);
        if (cur_mode == MD_LMR)  addr = cur_mrv;
        if (cur_mode == MD_PALL) addr[A10] = 1'b1;
      end
      SQ_GAP: begin
        cs_n = ~cur_banks;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sdram_cmd_issue.sv
module sdram_cmd_issue
  import sdram_cmd_pkg::*;
#(
  parameter bit DUAL   = 1'b1,
  parameter int TRFC   = 3,
  parameter int NRF_W  = 4,
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_mode,
  input  logic              req_bank_a,
  input  logic              req_bank_b,
  input  logic [NRF_W-1:0]  req_nrf,
  input  logic [ADDR_W-1:0] req_mrv,
  input  logic              err_clr,
  output logic [1:0]        sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              sd_cke,
  output logic              busy,
  output logic              err
);
  sd_mode_e          mode_in;
  sq_state_e         state;
  sd_mode_e          cur_mode;
  logic [1:0]        cur_banks;
  logic [ADDR_W-1:0] cur_mrv;
  sd_ctl_t           ctl;
  logic              accept;
  logic              reject;
  logic              cmd_fire;
  logic              last_done;

  assign mode_in = sd_mode_e'(req_mode);
  assign busy    = (state != SQ_IDLE);

  sdram_req_check #(.DUAL(DUAL)) u_check (
    .req_valid (req_valid),
    .busy      (busy),
    .mode      (mode_in),
    .bank_a    (req_bank_a),
    .bank_b    (req_bank_b),
    .accept    (accept),
    .reject    (reject)
  );

  sdram_seq #(.TRFC(TRFC), .NRF_W(NRF_W), .ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .mode      (mode_in),
    .bank_a    (req_bank_a),
    .bank_b    (req_bank_b),
    .nrf       (req_nrf),
    .mrv       (req_mrv),
    .state     (state),
    .cur_mode  (cur_mode),
    .cur_banks (cur_banks),
    .cur_mrv   (cur_mrv),
    .cmd_fire  (cmd_fire),
    .last_done (last_done)
  );

  sdram_cke_reg u_cke (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .mode   (mode_in),
    .cke    (sd_cke)
  );

  sdram_pin_drv #(.ADDR_W(ADDR_W)) u_pins (
    .state     (state),
    .cur_mode  (cur_mode),
    .cur_banks (cur_banks),
    .cur_mrv   (cur_mrv),
    .cs_n      (sd_cs_n),
    .ctl       (ctl),
    .addr      (sd_addr)
  );

  assign sd_ras_n = ctl.ras_n;
  assign sd_cas_n = ctl.cas_n;
  assign sd_we_n  = ctl.we_n;

  // A new rejection takes priority over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)       err <= 1'b0;
    else if (reject)  err <= 1'b1;
    else if (err_clr) err <= 1'b0;
  end
endmodule

// File: rtl/sdram_cmd_issue_chk.sv
module sdram_cmd_issue_chk #(
  parameter int TRFC   = 3,
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [2:0]        req_mode,
  input logic              req_bank_a,
  input logic              req_bank_b,
  input logic              err_clr,
  input logic [1:0]        sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [ADDR_W-1:0] sd_addr,
  input logic              sd_cke,
  input logic              busy,
  input logic              err,
  input logic              accept,
  input logic              cmd_fire,
  input logic              last_done
);
  logic        any_cs;
  logic        aref_pins;
  logic        pall_pins;
  logic [15:0] since_aref;
  logic        seen_aref;

  assign any_cs    = (sd_cs_n != 2'b11);
  assign aref_pins = any_cs && !sd_ras_n && !sd_cas_n && sd_we_n;
  assign pall_pins = any_cs && !sd_ras_n && sd_cas_n && !sd_we_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_aref <= '0;
      seen_aref  <= 1'b0;
    end else if (aref_pins) begin
      since_aref <= '0;
      seen_aref  <= 1'b1;
    end else if (since_aref != 16'hFFFF) begin
      since_aref <= since_aref + 1'b1;
    end
  end

  p_trfc_space_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (aref_pins && seen_aref) |-> (since_aref >= 16'(TRFC)));

  p_pall_a10_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pall_pins |-> sd_addr[10]);

  p_no_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !req_bank_a && !req_bank_b) |=> (sd_cs_n == 2'b11 && err && !busy));

  p_selfref_cke_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_mode == 3'd5) |=> (!sd_cke && aref_pins));

  p_pdown_nop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_mode == 3'd6) |=> (!sd_cke && sd_ras_n && sd_cas_n && sd_we_n));

  p_busy_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> err);

  p_fire_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire || last_done) |-> busy);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !err_clr) |=> err);

  p_rsvd_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == 3'd7) |=> err);

  p_idle_deselect_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sd_cs_n == 2'b11));
endmodule

bind sdram_cmd_issue sdram_cmd_issue_chk #(.TRFC(TRFC), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_mode   (req_mode),
  .req_bank_a (req_bank_a),
  .req_bank_b (req_bank_b),
  .err_clr    (err_clr),
  .sd_cs_n    (sd_cs_n),
  .sd_ras_n   (sd_ras_n),
  .sd_cas_n   (sd_cas_n),
  .sd_we_n    (sd_we_n),
  .sd_addr    (sd_addr),
  .sd_cke     (sd_cke),
  .busy       (busy),
  .err        (err),
  .accept     (accept),
  .cmd_fire   (cmd_fire),
  .last_done  (last_done)
);

// File: tb/sdram_cmd_issue_test.sv
module sdram_cmd_issue_test;
  localparam int CLK_PERIOD = 10;
  localparam int TRFC_D     = 3;
  localparam int TRFC_S     = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        s_valid = 1'b0;
  logic [2:0]  req_mode = 3'd0;
  logic        req_bank_a = 1'b0;
  logic        req_bank_b = 1'b0;
  logic [3:0]  req_nrf = 4'd0;
  logic [13:0] req_mrv = 14'd0;
  logic        err_clr = 1'b0;

  logic [1:0]  cs_n, s_cs_n;
  logic        ras_n, cas_n, we_n, s_ras_n, s_cas_n, s_we_n;
  logic [13:0] addr, s_addr;
  logic        cke, busy, err, s_cke, s_busy, s_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_issue #(.DUAL(1'b1), .TRFC(TRFC_D)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_bank_a(req_bank_a), .req_bank_b(req_bank_b), .req_nrf(req_nrf),
    .req_mrv(req_mrv), .err_clr(err_clr), .sd_cs_n(cs_n), .sd_ras_n(ras_n),
    .sd_cas_n(cas_n), .sd_we_n(we_n), .sd_addr(addr), .sd_cke(cke),
    .busy(busy), .err(err)
  );

  sdram_cmd_issue #(.DUAL(1'b0), .TRFC(TRFC_S)) uut_single (
    .clk(clk), .rst_n(rst_n), .req_valid(s_valid), .req_mode(req_mode),
    .req_bank_a(req_bank_a), .req_bank_b(req_bank_b), .req_nrf(req_nrf),
    .req_mrv(req_mrv), .err_clr(err_clr), .sd_cs_n(s_cs_n), .sd_ras_n(s_ras_n),
    .sd_cas_n(s_cas_n), .sd_we_n(s_we_n), .sd_addr(s_addr), .sd_cke(s_cke),
    .busy(s_busy), .err(s_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Issue a request; returns at the negedge of the first command cycle.
  task automatic do_req(input bit single, input logic [2:0] m, input logic a,
                        input logic b, input logic [3:0] n, input logic [13:0] v);
    @(negedge clk);
    req_mode = m; req_bank_a = a; req_bank_b = b; req_nrf = n; req_mrv = v;
    req_valid = !single; s_valid = single;
    @(negedge clk);
    req_valid = 1'b0; s_valid = 1'b0;
  endtask

  task automatic clr_err();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(cs_n == 2'b11, "R12 reset cs_n", cs_n, 2'b11);
    chk(!busy && !err, "R12 reset busy/err", {busy, err}, 0);
    chk(cke, "R12 reset cke", cke, 1);
  endtask

  task automatic t_pall();
    do_req(0, 3'd2, 1, 1, 0, 0);
    chk(cs_n == 2'b00 && {ras_n, cas_n, we_n} == 3'b010, "R1 pall pins",
        {cs_n, ras_n, cas_n, we_n}, 5'b00010);
    chk(addr[10] && busy, "R1 pall a10/busy", {addr[10], busy}, 2'b11);
    @(negedge clk);
    chk(!busy && cs_n == 2'b11, "R12 idle after pall", {busy, cs_n}, 3'b011);
  endtask

  task automatic t_pall_one_bank();
    do_req(0, 3'd2, 1, 0, 0, 0);
    chk(cs_n == 2'b11 && !busy, "R5 pall one bank ignored", {busy, cs_n}, 3'b011);
    chk(err, "R5 err set", err, 1);
    do_req(0, 3'd3, 0, 1, 0, 0);
    chk(cs_n == 2'b11 && !busy, "R5 aref one bank ignored", {busy, cs_n}, 3'b011);
    clr_err();
  endtask

  task automatic t_refresh_burst(input logic [3:0] n);
    int total, fires;
    total = (int'(n) + 1) * (TRFC_D + 1);
    fires = 0;
    do_req(0, 3'd3, 1, 1, n, 0);
    for (int i = 0; i < total; i++) begin
      bit is_cmd;
      is_cmd = (i % (TRFC_D + 1)) == 0;
      if (is_cmd) begin
        chk({ras_n, cas_n, we_n} == 3'b001 && cke, "R2 aref pins",
            {ras_n, cas_n, we_n, cke}, 4'b0011);
        fires++;
      end else begin
        chk({ras_n, cas_n, we_n} == 3'b111, "R2 nop gap", {ras_n, cas_n, we_n}, 3'b111);
      end
      chk(busy && cs_n == 2'b00, "R9 busy during burst", {busy, cs_n}, 3'b100);
      @(negedge clk);
    end
    chk(fires == int'(n) + 1, "R2 command count", fires, int'(n) + 1);
    chk(!busy && cs_n == 2'b11, "R9 busy falls after last gap", {busy, cs_n}, 3'b011);
  endtask

  task automatic t_lmr_bank_b();
    do_req(0, 3'd4, 0, 1, 0, 14'h2A5C);
    chk({ras_n, cas_n, we_n} == 3'b000, "R3 lmr pins", {ras_n, cas_n, we_n}, 0);
    chk(addr == 14'h2A5C, "R3 lmr addr", addr, 14'h2A5C);
    chk(cs_n == 2'b01, "R13 only device 1 selected", cs_n, 2'b01);
    @(negedge clk);
  endtask

  task automatic t_no_bank();
    do_req(0, 3'd4, 0, 0, 0, 14'h1111);
    chk(cs_n == 2'b11 && !busy, "R4 no bank no cmd", {busy, cs_n}, 3'b011);
    chk(err, "R4 err set", err, 1);
    clr_err();
    chk(!err, "R10 err cleared", err, 0);
  endtask

  task automatic t_rsvd();
    do_req(0, 3'd7, 1, 1, 0, 0);
    chk(cs_n == 2'b11 && !busy, "R11 reserved ignored", {busy, cs_n}, 3'b011);
    chk(err, "R11 err set", err, 1);
    clr_err();
  endtask

  task automatic t_busy_reject();
    do_req(0, 3'd3, 1, 1, 0, 0);
    req_mode = 3'd4; req_bank_a = 1; req_bank_b = 1; req_mrv = 14'h3FFF;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk({ras_n, cas_n, we_n} == 3'b111, "R9 busy request not issued",
        {ras_n, cas_n, we_n}, 3'b111);
    chk(err, "R9 busy request sets err", err, 1);
    wait_idle();
    @(negedge clk);
    chk(cs_n == 2'b11 && !busy, "R9 no late command", {busy, cs_n}, 3'b011);
    clr_err();
  endtask

  task automatic t_err_race();
    do_req(0, 3'd2, 0, 0, 0, 0);
    chk(err, "R10 err set before race", err, 1);
    @(negedge clk);
    err_clr = 1'b1; req_valid = 1'b1; req_bank_a = 0; req_bank_b = 0;
    @(negedge clk);
    err_clr = 1'b0; req_valid = 1'b0;
    chk(err, "R10 set wins over clear", err, 1);
    clr_err();
    chk(!err, "R10 clear alone", err, 0);
  endtask

  task automatic t_self_power();
    do_req(0, 3'd5, 1, 1, 0, 0);
    chk({ras_n, cas_n, we_n} == 3'b001 && !cke && cs_n == 2'b00, "R7 self-refresh",
        {cs_n, ras_n, cas_n, we_n, cke}, 6'b000010);
    @(negedge clk);
    chk(!cke && !busy, "R7 cke held low", {cke, busy}, 0);
    do_req(0, 3'd6, 1, 1, 0, 0);
    chk({ras_n, cas_n, we_n} == 3'b111 && !cke && cs_n == 2'b00, "R8 power-down",
        {cs_n, ras_n, cas_n, we_n, cke}, 6'b001110);
    @(negedge clk);
    chk(!cke, "R8 cke stays low", cke, 0);
    do_req(0, 3'd0, 1, 1, 0, 0);
    chk(cke && {ras_n, cas_n, we_n} == 3'b111, "R7 normal restores cke",
        {cke, ras_n, cas_n, we_n}, 4'b1111);
    @(negedge clk);
  endtask

  task automatic t_single();
    do_req(1, 3'd4, 0, 1, 0, 14'h0123);
    chk(s_cs_n == 2'b11 && !s_busy && s_err, "R6 absent device bit ignored",
        {s_busy, s_err, s_cs_n}, 4'b0111);
    clr_err();
    do_req(1, 3'd4, 1, 0, 0, 14'h0123);
    chk(s_cs_n == 2'b10 && s_addr == 14'h0123, "R6 device 0 lmr",
        {s_cs_n, s_addr}, {2'b10, 14'h0123});
    chk(!s_err, "R6 no err on legal", s_err, 0);
    @(negedge clk);
    do_req(1, 3'd2, 1, 0, 0, 0);
    chk(s_cs_n == 2'b10 && {s_ras_n, s_cas_n, s_we_n} == 3'b010, "R13 single pall cs",
        {s_cs_n, s_ras_n, s_cas_n, s_we_n}, 5'b10010);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pall();
    t_pall_one_bank();
    t_refresh_burst(4'd2);
    t_refresh_burst(4'd0);
    t_lmr_bank_b();
    t_no_bank();
    t_rsvd();
    t_busy_reject();
    t_err_race();
    t_self_power();
    t_single();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule